// File: doc/BRIEF.md
# HDLC Receive Interrupt Qualifier

This block decides when the receive side of an HDLC controller raises its receive interrupt and its companion special-condition interrupt. It watches a one-cycle strobe that marks each byte entering the receive queue, together with the live queue occupancy count. A two-bit mode field selects how requests are qualified: never, once on the first byte after the block was armed, or whenever the queue holds more characters than a programmable three-bit threshold.

First-byte mode is one-shot. After one byte has raised the interrupt, later bytes are ignored until software pulses a re-arm command or applies a software reset. Each interrupt has its own pending flag that software clears by writing one. The special-condition interrupt uses the same qualifying event as the receive interrupt, gated by a flag that the receiver raises when the byte or queue state carries a special condition. The deframer, the queue storage and the bus decoding sit outside this block.

Top module: `hdlc_rx_irq_qual`

## Requirements
- R1: While rst_n is low, rx_irq and sp_irq are 0 and the block is armed for first-byte mode.
- R2: The mode_sel encoding is 2'b00 disabled, 2'b01 first-byte, 2'b10 threshold, and 2'b11 disabled. In the two disabled codes no input sets either pending flag.
- R3: In first-byte mode, a byte_rx pulse while armed sets rx_irq at the next clock edge.
- R4: Once a first-byte event has fired, further byte_rx pulses set nothing until the block is re-armed.
- R5: A one-cycle rearm pulse re-arms first-byte mode, so the next byte_rx sets rx_irq again.
- R6: In threshold mode, rx_irq is set at every clock edge where occupancy (4 bits, range 0 to 8) is strictly greater than thresh (3 bits). Equality does not set it.
- R7: sp_irq is set at the same edge as rx_irq's qualifying event, but only if sp_cond is 1 in that cycle.
- R8: clr_rx and clr_sp clear their pending flags at the next edge. If a qualifying set happens in the same cycle, the flag stays 1.
- R9: soft_rst clears both pending flags at the next edge, and takes priority over a set in the same cycle. It also re-arms first-byte mode.
- R10: Bytes received while in disabled or threshold mode do not use up the first-byte arming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| soft_rst | input | 1 | Synchronous software reset: clears the flags and re-arms |
| mode_sel | input | 2 | Qualification mode |
| thresh | input | 3 | Occupancy threshold for threshold mode |
| occupancy | input | 4 | Live receive queue fill count |
| byte_rx | input | 1 | One-cycle strobe per received byte |
| sp_cond | input | 1 | A special condition is present with this event |
| rearm | input | 1 | Command: interrupt on the next received byte |
| clr_rx | input | 1 | Write-one-to-clear for rx_irq |
| clr_sp | input | 1 | Write-one-to-clear for sp_irq |
| rx_irq | output | 1 | Receive interrupt pending |
| sp_irq | output | 1 | Special-condition interrupt pending |

## Verification
The assertions check the following on every cycle:
- A rise of either pending flag always follows a qualifying event in the previous cycle.
- The special flag never rises without sp_cond.
- Software reset always empties both flags.
- Threshold mode with an over-threshold occupancy always leaves rx_irq set.
- A clear in a disabled mode always takes effect.

The one-shot arming history can only be shown by the bench's ordered scenarios. These cover a repeat byte after a fired event, a re-arm, threshold-mode bytes leaving the arming intact, and a software reset arriving together with a byte.

// File: rtl/hrq_pkg.sv
package hrq_pkg;

   typedef enum logic [1:0] {
      HRQ_OFF     = 2'b00,
      HRQ_FIRST   = 2'b01,
      HRQ_THRESH  = 2'b10,
      HRQ_OFF_ALT = 2'b11
   } hrq_mode_e;

   localparam int HRQ_NCHAN  = 2;
   localparam int HRQ_CH_RX  = 0;
   localparam int HRQ_CH_SP  = 1;

endpackage

// File: rtl/hrq_mode_dec.sv
module hrq_mode_dec
   import hrq_pkg::*;
(
   input  logic [1:0] mode_sel,
   output logic       first_en,
   output logic       thresh_en
);

   hrq_mode_e mode;

   always_comb begin
      mode      = hrq_mode_e'(mode_sel);
      first_en  = 1'b0;
      thresh_en = 1'b0;
      unique case (mode)
         HRQ_FIRST:  first_en  = 1'b1;
         HRQ_THRESH: thresh_en = 1'b1;
         default: ;
      endcase
   end

endmodule

// File: rtl/hrq_first_arm.sv
module hrq_first_arm (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic rearm,
   input  logic first_en,
   input  logic byte_rx,
   output logic fire
);

   logic armed_q;

   // a byte only consumes the arming in first-byte mode
   assign fire = first_en & byte_rx & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)               armed_q <= 1'b1;
      else if (soft_rst | rearm) armed_q <= 1'b1;
      else if (fire)            armed_q <= 1'b0;
   end

endmodule

// File: rtl/hrq_occ_cmp.sv
module hrq_occ_cmp #(
   parameter int OCC_W      = 4,
   parameter int THR_W      = 3,
   parameter bit REGISTERED = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             thresh_en,
   input  logic [OCC_W-1:0] occupancy,
   input  logic [THR_W-1:0] thresh,
   output logic             over
);

   logic [OCC_W-1:0] thr_ext;
   logic             over_c;

   assign thr_ext = OCC_W'(thresh);
   assign over_c  = thresh_en & (occupancy > thr_ext);

   if (REGISTERED) begin : g_reg
      logic over_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) over_q <= 1'b0;
         else        over_q <= over_c;
      end
      assign over = over_q;
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign over = over_c;
   end

endmodule

// File: rtl/hrq_pend_flag.sv
module hrq_pend_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic soft_rst,
   input  logic set,
   input  logic clr,
   output logic q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= 1'b0;
      else if (soft_rst) q <= 1'b0;
      else if (set)      q <= 1'b1;
      else if (clr)      q <= 1'b0;
   end

endmodule

// File: rtl/hdlc_rx_irq_qual.sv
module hdlc_rx_irq_qual
   import hrq_pkg::*;
#(
   parameter int DEPTH   = 8,
   parameter int OCC_W   = 4,
   parameter int THR_W   = 3,
   parameter bit CMP_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             soft_rst,
   input  logic [1:0]       mode_sel,
   input  logic [THR_W-1:0] thresh,
   input  logic [OCC_W-1:0] occupancy,
   input  logic             byte_rx,
   input  logic             sp_cond,
   input  logic             rearm,
   input  logic             clr_rx,
   input  logic             clr_sp,
   output logic             rx_irq,
   output logic             sp_irq
);

   localparam int OCC_MIN_W = $clog2(DEPTH + 1);

   if (OCC_W < OCC_MIN_W) begin : g_bad_occ
      $error("occupancy width too small for DEPTH");
   end
   if (THR_W > OCC_W) begin : g_bad_thr
      $error("threshold wider than occupancy");
   end

   logic first_en, thresh_en, fire, over, qual;
   logic [HRQ_NCHAN-1:0] set_v, clr_v, pend_v;

   hrq_mode_dec u_dec (
      .mode_sel  (mode_sel),
      .first_en  (first_en),
      .thresh_en (thresh_en)
   );

   hrq_first_arm u_arm (
      .clk      (clk),
      .rst_n    (rst_n),
      .soft_rst (soft_rst),
      .rearm    (rearm),
      .first_en (first_en),
      .byte_rx  (byte_rx),
      .fire     (fire)
   );

   hrq_occ_cmp #(
      .OCC_W      (OCC_W),
      .THR_W      (THR_W),
      .REGISTERED (CMP_REG)
   ) u_cmp (
      .clk       (clk),
      .rst_n     (rst_n),
      .thresh_en (thresh_en),
      .occupancy (occupancy),
      .thresh    (thresh),
      .over      (over)
   );

   assign qual = fire | over;

   assign set_v[HRQ_CH_RX] = qual;
   assign set_v[HRQ_CH_SP] = qual & sp_cond;
   assign clr_v[HRQ_CH_RX] = clr_rx;
   assign clr_v[HRQ_CH_SP] = clr_sp;

   for (genvar i = 0; i < HRQ_NCHAN; i++) begin : g_pend
      hrq_pend_flag u_flag (
         .clk      (clk),
         .rst_n    (rst_n),
         .soft_rst (soft_rst),
         .set      (set_v[i]),
         .clr      (clr_v[i]),
         .q        (pend_v[i])
      );
   end

   assign rx_irq = pend_v[HRQ_CH_RX];
   assign sp_irq = pend_v[HRQ_CH_SP];

endmodule

// File: rtl/hdlc_rx_irq_qual_chk.sv
module hdlc_rx_irq_qual_chk #(
   parameter int OCC_W   = 4,
   parameter int THR_W   = 3,
   parameter bit CMP_REG = 1'b0
) (
   input logic             clk,
   input logic             rst_n,
   input logic             soft_rst,
   input logic [1:0]       mode_sel,
   input logic [THR_W-1:0] thresh,
   input logic [OCC_W-1:0] occupancy,
   input logic             byte_rx,
   input logic             sp_cond,
   input logic             clr_rx,
   input logic             clr_sp,
   input logic             rx_irq,
   input logic             sp_irq
);

   logic over_now;
   assign over_now = (mode_sel == 2'b10) && (occupancy > OCC_W'(thresh));

   // R3 R6
   rx_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rx_irq) |-> $past((mode_sel == 2'b01 && byte_rx) || over_now)
         || CMP_REG);

   // R7
   sp_needs_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sp_irq) |-> $past(sp_cond) || CMP_REG);

   // R9
   soft_rst_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (!rx_irq && !sp_irq));

   // R6
   thresh_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!CMP_REG && over_now && !soft_rst) |=> rx_irq);

   // R2 R8
   off_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_sel[0] == mode_sel[1] && clr_rx && clr_sp && !CMP_REG)
         |=> (!rx_irq && !sp_irq));

endmodule

bind hdlc_rx_irq_qual hdlc_rx_irq_qual_chk #(
   .OCC_W   (OCC_W),
   .THR_W   (THR_W),
   .CMP_REG (CMP_REG)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .soft_rst  (soft_rst),
   .mode_sel  (mode_sel),
   .thresh    (thresh),
   .occupancy (occupancy),
   .byte_rx   (byte_rx),
   .sp_cond   (sp_cond),
   .clr_rx    (clr_rx),
   .clr_sp    (clr_sp),
   .rx_irq    (rx_irq),
   .sp_irq    (sp_irq)
);

// File: tb/tb_hdlc_rx_irq_qual.sv
`timescale 1ns/1ps
module tb_hdlc_rx_irq_qual;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       soft_rst = 1'b0;
   logic [1:0] mode_sel = 2'b00;
   logic [2:0] thresh = 3'd0;
   logic [3:0] occupancy = 4'd0;
   logic       byte_rx = 1'b0, sp_cond = 1'b0, rearm = 1'b0;
   logic       clr_rx = 1'b0, clr_sp = 1'b0;
   logic       rx_irq, sp_irq;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [1:0] exp_q[$];
   string      tag_q[$];

   always #2 clk = ~clk;

   hdlc_rx_irq_qual dut (
      .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .mode_sel(mode_sel),
      .thresh(thresh), .occupancy(occupancy), .byte_rx(byte_rx),
      .sp_cond(sp_cond), .rearm(rearm), .clr_rx(clr_rx), .clr_sp(clr_sp),
      .rx_irq(rx_irq), .sp_irq(sp_irq)
   );

   task automatic compare(input logic [1:0] exp, input string tag);
      checks++;
      if ({rx_irq, sp_irq} !== exp) begin
         failures++;
         $display("FAIL %s: rx/sp actual=%b%b expected=%b", tag, rx_irq, sp_irq, exp);
      end
   endtask

   // driver: one cycle of stimulus, expected flags after the next edge
   task automatic step(input logic [1:0] m, input logic [2:0] thr,
                       input logic [3:0] occ, input logic b, input logic sc,
                       input logic ra, input logic cr, input logic cs,
                       input logic sr, input logic [1:0] exp, input string tag);
      @(negedge clk);
      mode_sel = m; thresh = thr; occupancy = occ; byte_rx = b;
      sp_cond = sc; rearm = ra; clr_rx = cr; clr_sp = cs; soft_rst = sr;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
   endtask

   // monitor: check just after each edge
   always @(posedge clk) begin
      #1;
      if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
   end

   initial begin
      repeat (3) @(negedge clk);
      compare(2'b00, "R1 reset state");
      rst_n = 1'b1;
      //    mode  thr occ b sc ra cr cs sr  exp
      step(2'b01, 0, 0, 1, 0, 0, 0, 0, 0, 2'b10, "R3 first byte");
      step(2'b01, 0, 0, 0, 0, 0, 0, 0, 0, 2'b10, "R3 pending holds");
      step(2'b01, 0, 0, 0, 0, 0, 1, 0, 0, 2'b00, "R8 clear");
      step(2'b01, 0, 0, 1, 1, 0, 0, 0, 0, 2'b00, "R4 one-shot");
      step(2'b01, 0, 0, 0, 0, 1, 0, 0, 0, 2'b00, "R5 rearm alone");
      step(2'b01, 0, 0, 1, 1, 0, 0, 0, 0, 2'b11, "R5 R7 byte after rearm");
      step(2'b01, 0, 0, 0, 0, 0, 1, 1, 0, 2'b00, "R8 clear both");
      step(2'b00, 0, 0, 0, 0, 1, 0, 0, 0, 2'b00, "R5 rearm");
      step(2'b00, 0, 8, 1, 1, 0, 0, 0, 0, 2'b00, "R2 mode 00");
      step(2'b11, 0, 8, 1, 1, 0, 0, 0, 0, 2'b00, "R2 mode 11");
      step(2'b10, 3, 3, 1, 1, 0, 0, 0, 0, 2'b00, "R6 equal no set");
      step(2'b10, 3, 4, 0, 0, 0, 0, 0, 0, 2'b10, "R6 over sets");
      step(2'b10, 3, 4, 0, 0, 0, 1, 0, 0, 2'b10, "R8 set beats clear");
      step(2'b10, 3, 0, 0, 0, 0, 1, 0, 0, 2'b00, "R8 clear when below");
      step(2'b10, 7, 8, 0, 1, 0, 0, 0, 0, 2'b11, "R7 R6 full queue");
      step(2'b10, 7, 7, 0, 1, 0, 1, 1, 0, 2'b00, "R8 clear at equal");
      step(2'b01, 0, 0, 1, 0, 0, 0, 0, 0, 2'b10, "R10 arming kept");
      step(2'b01, 0, 0, 1, 1, 0, 0, 0, 1, 2'b00, "R9 soft reset wins");
      step(2'b01, 0, 0, 1, 1, 0, 0, 0, 0, 2'b11, "R9 rearmed");
      step(2'b10, 0, 5, 0, 1, 0, 0, 0, 1, 2'b00, "R9 soft vs threshold");
      step(2'b00, 0, 0, 0, 0, 0, 0, 0, 0, 2'b00, "R2 idle");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (2000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog: actual=timeout expected=done");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule